// File: doc/BRIEF.md
# FMA Special-Operand Resolver

This block sits in front of the arithmetic datapath of a double-precision fused multiply-add unit that computes z + x*y. With the product-negate option set, it computes z - x*y. The block takes the three raw 64-bit operands and classifies each one as zero, subnormal, normal, infinity, quiet NaN or signaling NaN. From those classes it decides whether the final answer is already fixed by the special operands. When it is, the block supplies that answer directly.

When the answer is fixed, the block raises a bypass flag and drives the 64-bit result to use. It also raises an invalid-operation flag for signaling NaNs, for an infinity multiplied by zero, and for infinities that cancel. When both factors are finite and nonzero and z is finite, bypass stays low and the datapath must produce the sum. The block is purely combinational. It holds no state.

Top module: `fma_special_resolver`

## Requirements
- R1: Operand format is sign in bit 63, exponent in bits 62:52 and fraction in bits 51:0. The exponent field decides the class as follows:
  - An all-ones exponent with a zero fraction is infinity.
  - An all-ones exponent with a nonzero fraction is a NaN. Fraction bit 51 set makes it quiet; clear makes it signaling.
  - A zero exponent with a zero fraction is zero.
  - A zero exponent with a nonzero fraction is subnormal.
  - Any other exponent is normal.
- R2: When any operand is a NaN, the result is a NaN taken by priority. Any signaling NaN beats any quiet NaN. Within the same kind, z beats x and x beats y.
- R3: A selected signaling NaN sets invalid and is returned with fraction bit 51 forced to 1, all other bits unchanged. A selected quiet NaN is returned unchanged with invalid low.
- R4: With no NaN present, infinity times zero (either order) sets invalid and returns the default NaN parameter (default 0x7FF8000000000000), whatever z is.
- R5: With no NaN present, if the product is infinite and z is infinite with a sign different from the effective product sign, invalid is set and the default NaN is returned. The effective product sign is sign(x) XOR sign(y), inverted when neg_prod is 1.
- R6: Otherwise an infinite product returns infinity (all-ones exponent, zero fraction) with the effective product sign. Invalid stays low.
- R7: With a finite product and an infinite z, the result is z unchanged.
- R8: With a zero product and a zero z:
  - If z's sign equals the effective product sign, the result is z.
  - Otherwise the result is +0, or -0 when rnd_mode is 2'b11 (round toward minus infinity). Other rnd_mode codes (00, 01, 10) give +0.
- R9: With a zero product and a nonzero finite z (normal or subnormal), the result is z unchanged.
- R10: When both x and y are nonzero finite values and z is finite (zero included), bypass is 0, invalid is 0 and result is all zeros.
- R11: In every other case bypass is 1. Invalid is 1 only in the cases of R3 (signaling), R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 64 | Addend operand |
| op_x | input | 64 | First factor |
| op_y | input | 64 | Second factor |
| neg_prod | input | 1 | 1 negates the product (z - x*y) |
| rnd_mode | input | 2 | Rounding mode; 2'b11 is toward minus infinity |
| bypass | output | 1 | Result is fixed by special operands |
| result | output | 64 | Bypass result; zero when bypass is low |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Random operands are drawn with an even spread over the six classes, so that every pairing of classes appears many times. Random signs, fractions, negate flag and rounding mode are mixed in. Directed cases then cover each priority step:
- Several NaN mixes show whether the z-x-y and signaling-over-quiet orders hold.
- Infinity times zero against an infinite z shows whether R4 wins over R5.
- Opposite and equal infinity signs under both negate settings show the effective-sign rule.
- Signed-zero sums in each rounding mode show the minus-infinity exception.
- Normal and subnormal factor pairs show that only finite nonzero products reach the datapath.

// File: rtl/fma_sp_pkg.sv
package fma_sp_pkg;

  // Operand classes, ordered from plain to special
  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } opcls_e;

  // Number of operands and their priority slots
  localparam int NOPS   = 3;
  localparam int SLOT_Z = 0;
  localparam int SLOT_X = 1;
  localparam int SLOT_Y = 2;

  // Rounding-mode code for rounding toward minus infinity
  localparam logic [1:0] RM_TO_NEG = 2'b11;

  function automatic logic cls_is_nan(input opcls_e c);
    return (c == CL_QNAN) || (c == CL_SNAN);
  endfunction

  function automatic logic cls_is_finite_nz(input opcls_e c);
    return (c == CL_SUB) || (c == CL_NORM);
  endfunction

endpackage

// File: rtl/fma_sp_classify.sv
module fma_sp_classify
  import fma_sp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output opcls_e       cls_o,
  output logic         sign_o
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              exp_min;
  logic              frac_nz;

  assign sign_o  = op_i[W-1];
  assign exp_f   = op_i[W-2:FRAC_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)                  cls_o = CL_INF;
      else if (frac_f[FRAC_W-1])     cls_o = CL_QNAN;
      else                           cls_o = CL_SNAN;
    end else if (exp_min) begin
      cls_o = frac_nz ? CL_SUB : CL_ZERO;
    end else begin
      cls_o = CL_NORM;
    end
  end

endmodule

// File: rtl/fma_sp_nan_pick.sv
module fma_sp_nan_pick
  import fma_sp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] opnd_i [NOPS],
  input  opcls_e       cls_i  [NOPS],
  output logic         hit_o,
  output logic         sig_o,
  output logic [W-1:0] val_o
);

  localparam logic [W-1:0] QUIET_MASK =
    {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // Later assignments win: quiet pass first, signaling pass second,
  // each scanned from the lowest priority slot to the highest.
  always_comb begin
    hit_o = 1'b0;
    sig_o = 1'b0;
    val_o = '0;
    for (int i = NOPS - 1; i >= 0; i--) begin
      if (cls_i[i] == CL_QNAN) begin
        hit_o = 1'b1;
        sig_o = 1'b0;
        val_o = opnd_i[i];
      end
    end
    for (int i = NOPS - 1; i >= 0; i--) begin
      if (cls_i[i] == CL_SNAN) begin
        hit_o = 1'b1;
        sig_o = 1'b1;
        val_o = opnd_i[i] | QUIET_MASK;
      end
    end
  end

endmodule

// File: rtl/fma_sp_special_pick.sv
module fma_sp_special_pick
  import fma_sp_pkg::*;
#(
  parameter int EXP_W              = 11,
  parameter int FRAC_W             = 52,
  localparam int W                 = 1 + EXP_W + FRAC_W,
  parameter logic [W-1:0] DFLT_NAN = 64'h7FF8_0000_0000_0000
) (
  input  opcls_e       cls_z_i,
  input  opcls_e       cls_x_i,
  input  opcls_e       cls_y_i,
  input  logic         eff_sign_i,
  input  logic         sign_z_i,
  input  logic [1:0]   rnd_mode_i,
  input  logic [W-1:0] op_z_i,
  output logic         hit_o,
  output logic         inv_o,
  output logic [W-1:0] val_o,
  output logic         inf_times_zero_o,
  output logic         inf_cancel_o
);

  logic prod_inf;
  logic prod_zero;
  logic z_inf;
  logic z_zero;

  assign prod_inf  = (cls_x_i == CL_INF)  || (cls_y_i == CL_INF);
  assign prod_zero = (cls_x_i == CL_ZERO) || (cls_y_i == CL_ZERO);
  assign z_inf     = (cls_z_i == CL_INF);
  assign z_zero    = (cls_z_i == CL_ZERO);

  assign inf_times_zero_o = prod_inf && prod_zero;
  assign inf_cancel_o     = prod_inf && !prod_zero && z_inf &&
                            (sign_z_i != eff_sign_i);

  always_comb begin
    hit_o = 1'b1;
    inv_o = 1'b0;
    val_o = '0;
    if (inf_times_zero_o || inf_cancel_o) begin
      inv_o = 1'b1;
      val_o = DFLT_NAN;
    end else if (prod_inf) begin
      val_o = {eff_sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (z_inf) begin
      val_o = op_z_i;
    end else if (prod_zero) begin
      if (z_zero && (sign_z_i != eff_sign_i))
        val_o = {(rnd_mode_i == RM_TO_NEG), {(W-1){1'b0}}};
      else
        val_o = op_z_i;
    end else begin
      hit_o = 1'b0;
    end
  end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_sp_pkg::*;
#(
  parameter int EXP_W              = 11,
  parameter int FRAC_W             = 52,
  localparam int W                 = 1 + EXP_W + FRAC_W,
  parameter logic [W-1:0] DFLT_NAN = 64'h7FF8_0000_0000_0000
) (
  input  logic [W-1:0] op_z,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic         neg_prod,
  input  logic [1:0]   rnd_mode,
  output logic         bypass,
  output logic [W-1:0] result,
  output logic         invalid
);

  logic [W-1:0] opnd [NOPS];
  opcls_e       cls  [NOPS];
  logic [NOPS-1:0] sgn;

  assign opnd[SLOT_Z] = op_z;
  assign opnd[SLOT_X] = op_x;
  assign opnd[SLOT_Y] = op_y;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fma_sp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i   (opnd[g]),
      .cls_o  (cls[g]),
      .sign_o (sgn[g])
    );
  end

  // Named events for the checker
  logic         nan_hit;
  logic         nan_sig;
  logic [W-1:0] nan_val;
  logic         eff_sign;
  logic         sp_hit;
  logic         sp_inv;
  logic [W-1:0] sp_val;
  logic         inf_times_zero;
  logic         inf_cancel;

  assign eff_sign = sgn[SLOT_X] ^ sgn[SLOT_Y] ^ neg_prod;

  fma_sp_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .opnd_i (opnd),
    .cls_i  (cls),
    .hit_o  (nan_hit),
    .sig_o  (nan_sig),
    .val_o  (nan_val)
  );

  fma_sp_special_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DFLT_NAN(DFLT_NAN)) u_sp (
    .cls_z_i          (cls[SLOT_Z]),
    .cls_x_i          (cls[SLOT_X]),
    .cls_y_i          (cls[SLOT_Y]),
    .eff_sign_i       (eff_sign),
    .sign_z_i         (sgn[SLOT_Z]),
    .rnd_mode_i       (rnd_mode),
    .op_z_i           (op_z),
    .hit_o            (sp_hit),
    .inv_o            (sp_inv),
    .val_o            (sp_val),
    .inf_times_zero_o (inf_times_zero),
    .inf_cancel_o     (inf_cancel)
  );

  always_comb begin
    if (nan_hit) begin
      bypass  = 1'b1;
      result  = nan_val;
      invalid = nan_sig;
    end else begin
      bypass  = sp_hit;
      result  = sp_val;
      invalid = sp_inv;
    end
  end

endmodule

// File: rtl/fma_sp_checker.sv
module fma_sp_checker #(
  parameter int EXP_W              = 11,
  parameter int FRAC_W             = 52,
  localparam int W                 = 1 + EXP_W + FRAC_W,
  parameter logic [W-1:0] DFLT_NAN = 64'h7FF8_0000_0000_0000
) (
  input logic [W-1:0] op_z,
  input logic [W-1:0] op_x,
  input logic [W-1:0] op_y,
  input logic         neg_prod,
  input logic [1:0]   rnd_mode,
  input logic         bypass,
  input logic [W-1:0] result,
  input logic         invalid,
  input logic         nan_hit,
  input logic         inf_times_zero,
  input logic         inf_cancel
);

  function automatic logic top_exp(input logic [W-1:0] v);
    return v[W-2:FRAC_W] == {EXP_W{1'b1}};
  endfunction
  function automatic logic is_nan(input logic [W-1:0] v);
    return top_exp(v) && (v[FRAC_W-1:0] != '0);
  endfunction
  function automatic logic is_snan(input logic [W-1:0] v);
    return is_nan(v) && !v[FRAC_W-1];
  endfunction
  function automatic logic is_inf(input logic [W-1:0] v);
    return top_exp(v) && (v[FRAC_W-1:0] == '0);
  endfunction
  function automatic logic is_zero(input logic [W-1:0] v);
    return v[W-2:0] == '0;
  endfunction

  logic nan_any, snan_any, pzero, pinf, esign;

  always_comb begin
    nan_any  = is_nan(op_z) || is_nan(op_x) || is_nan(op_y);
    snan_any = is_snan(op_z) || is_snan(op_x) || is_snan(op_y);
    pzero    = is_zero(op_x) || is_zero(op_y);
    pinf     = is_inf(op_x) || is_inf(op_y);
    esign    = op_x[W-1] ^ op_y[W-1] ^ neg_prod;

    a_r2_nan_result: assert (!nan_any || (nan_hit && bypass && is_nan(result)))
      else $error("a_r2_nan_result");
    a_r3_snan_invalid: assert (!snan_any || (invalid && result[FRAC_W-1]))
      else $error("a_r3_snan_invalid");
    a_r4_inf_zero: assert (nan_any || !inf_times_zero || (invalid && result == DFLT_NAN))
      else $error("a_r4_inf_zero");
    a_r5_inf_cancel: assert (nan_any || !inf_cancel || (invalid && result == DFLT_NAN))
      else $error("a_r5_inf_cancel");
    a_r8_zero_sign: assert (nan_any || pinf || !pzero || !is_zero(op_z) ||
                            (op_z[W-1] == esign) ||
                            (!invalid && result == {(rnd_mode == 2'b11), {(W-1){1'b0}}}))
      else $error("a_r8_zero_sign");
    a_r10_compute: assert (bypass || (!invalid && result == '0 &&
                           !pzero && !pinf && !is_inf(op_z) && !nan_any))
      else $error("a_r10_compute");
    a_r11_invalid_src: assert (!invalid || snan_any || inf_times_zero || inf_cancel)
      else $error("a_r11_invalid_src");
  end

endmodule

bind fma_special_resolver fma_sp_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DFLT_NAN(DFLT_NAN)
) u_chk (
  .op_z           (op_z),
  .op_x           (op_x),
  .op_y           (op_y),
  .neg_prod       (neg_prod),
  .rnd_mode       (rnd_mode),
  .bypass         (bypass),
  .result         (result),
  .invalid        (invalid),
  .nan_hit        (nan_hit),
  .inf_times_zero (inf_times_zero),
  .inf_cancel     (inf_cancel)
);

// File: tb/sim_fma_special_resolver.sv
`timescale 1ns/1ps
module sim_fma_special_resolver;

  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] SUBN = 64'h0000_0000_0000_0005;
  localparam logic [63:0] QN1  = 64'h7FF8_0000_0000_0011;
  localparam logic [63:0] QN2  = 64'hFFF8_0000_0000_0022;
  localparam logic [63:0] SN1  = 64'h7FF0_0000_0000_0033;
  localparam logic [63:0] SN2  = 64'hFFF4_0000_0000_0044;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] op_z, op_x, op_y, result;
  logic        neg_prod, bypass, invalid;
  logic [1:0]  rnd_mode;
  int total = 0;
  int bad   = 0;

  fma_special_resolver u0 (
    .op_z(op_z), .op_x(op_x), .op_y(op_y), .neg_prod(neg_prod),
    .rnd_mode(rnd_mode), .bypass(bypass), .result(result), .invalid(invalid)
  );

  // Bench class codes: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qnan, 5 snan (R1)
  function automatic int kind(input logic [63:0] v);
    int e = int'(v[62:52]);
    if (e == 2047) begin
      if (v[51:0] == 0) return 3;
      return v[51] ? 4 : 5;
    end
    if (e == 0) return (v[51:0] == 0) ? 0 : 1;
    return 2;
  endfunction

  task automatic model(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm,
                       output logic eb, output logic ei, output logic [63:0] er,
                       output string tg);
    int kz = kind(z), kx = kind(x), ky = kind(y);
    logic ps = x[63] ^ y[63] ^ ng;
    eb = 1; ei = 0; er = 0;
    if (kz == 5)      begin ei = 1; er = z | (64'd1 << 51); tg = "R3"; end
    else if (kx == 5) begin ei = 1; er = x | (64'd1 << 51); tg = "R3"; end
    else if (ky == 5) begin ei = 1; er = y | (64'd1 << 51); tg = "R3"; end
    else if (kz == 4) begin er = z; tg = "R2"; end
    else if (kx == 4) begin er = x; tg = "R2"; end
    else if (ky == 4) begin er = y; tg = "R2"; end
    else if ((kx == 3 && ky == 0) || (kx == 0 && ky == 3)) begin ei = 1; er = DNAN; tg = "R4"; end
    else if (kx == 3 || ky == 3) begin
      if (kz == 3 && z[63] != ps) begin ei = 1; er = DNAN; tg = "R5"; end
      else begin er = ps ? NINF : PINF; tg = "R6"; end
    end
    else if (kz == 3) begin er = z; tg = "R7"; end
    else if (kx == 0 || ky == 0) begin
      if (kz == 0) begin
        tg = "R8";
        er = (z[63] == ps) ? z : ((rm == 2'b11) ? NZ : PZ);
      end else begin er = z; tg = "R9"; end
    end
    else begin eb = 0; tg = "R10"; end
  endtask

  task automatic run(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm,
                     input string force_tag);
    logic eb, ei; logic [63:0] er; string tg;
    @(negedge clk);
    op_z = z; op_x = x; op_y = y; neg_prod = ng; rnd_mode = rm;
    model(z, x, y, ng, rm, eb, ei, er, tg);
    if (force_tag != "") tg = force_tag;
    #1;
    total++;
    if (bypass !== eb || invalid !== ei || result !== er) begin
      bad++;
      $display("FAIL %s R11: got byp=%0b inv=%0b res=%h exp byp=%0b inv=%0b res=%h",
               tg, bypass, invalid, result, eb, ei, er);
    end
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] f = {$urandom, $urandom};
    logic s = f[63];
    case ($urandom % 6)
      0: return {s, 63'd0};
      1: return {s, 11'd0, f[51:1], 1'b1};
      2: return {s, 11'(1 + ($urandom % 2046)), f[51:0]};
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, f[50:1], 1'b1};
    endcase
  endfunction

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog R11: got hang exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // idle state: all zero inputs give +0 bypass (R8)
    run(PZ, PZ, PZ, 0, 2'b00, "R8");
    // R1 classification at the edges
    run(SUBN, ONE, PZ, 0, 2'b00, "R1");
    run(64'h7FEF_FFFF_FFFF_FFFF, ONE, ONE, 0, 2'b00, "R1");
    // R2 priority
    run(QN1, SN1, QN2, 0, 2'b00, "R2");
    run(ONE, QN2, SN2, 0, 2'b00, "R2");
    run(QN2, QN1, ONE, 0, 2'b00, "R2");
    run(ONE, PINF, QN1, 0, 2'b00, "R2");
    // R3 signaling quieted, z first
    run(SN2, SN1, ONE, 0, 2'b00, "R3");
    // R4 inf*0 wins over infinite z
    run(NINF, PZ, PINF, 0, 2'b00, "R4");
    run(PINF, NINF, NZ, 1, 2'b11, "R4");
    // R5 cancelling infinities, both negate settings
    run(NINF, PINF, ONE, 0, 2'b00, "R5");
    run(PINF, PINF, ONE, 1, 2'b00, "R5");
    // R6 infinite product sign
    run(PINF, PINF, ONE, 0, 2'b00, "R6");
    run(ONE, NTWO, PINF, 1, 2'b00, "R6");
    // R7 finite product, infinite z
    run(NINF, ONE, SUBN, 0, 2'b00, "R7");
    run(PINF, PZ, ONE, 1, 2'b00, "R7");
    // R8 signed zero across rounding modes
    for (int m = 0; m < 4; m++) begin
      run(NZ, PZ, ONE, 0, 2'(m), "R8");
      run(NZ, NZ, ONE, 0, 2'(m), "R8");
      run(PZ, PZ, ONE, 1, 2'(m), "R8");
    end
    // R9 zero product, nonzero z
    run(SUBN, PZ, NTWO, 1, 2'b11, "R9");
    run(NTWO, ONE, NZ, 0, 2'b00, "R9");
    // R10 datapath cases
    run(PZ, ONE, NTWO, 0, 2'b11, "R10");
    run(SUBN, SUBN, SUBN, 1, 2'b00, "R10");
    // random mix
    for (int i = 0; i < 3000; i++)
      run(rnd_op(), rnd_op(), rnd_op(), 1'($urandom), 2'($urandom), "");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule